// File: doc/BRIEF.md
# Segment Table Translation Unit

This block turns a logical address, given as a segment number plus an offset into that segment, into a physical address. The segments are described by a table held in ordinary memory. Each segment owns two consecutive words in that table. The first word is the physical start of the segment. The second word is the length of the segment. Two configuration registers locate the table: one holds its starting word address and the other holds how many segments are currently in use.

A translation first compares the segment number against the segment count. An out-of-range number stops at once with a segment trap and no memory traffic. Otherwise the unit reads the two words of the entry and compares the offset against the segment length. It then returns either the sum of start and offset, or an offset trap. Requests, table reads and results all use valid/ready handshakes. A request is taken only when `req_valid` and `req_ready` are both high at a clock edge. A table read is issued when `tbl_rd_valid` and `tbl_rd_ready` are both high. Read data is taken on any cycle where `tbl_rsp_valid` is high, since the unit always has room for it. A result stays on the output, unchanged, until `res_ready` accepts it. Only one translation is in flight at a time.

Top module: `seg_xlate`

## Requirements
- R1: After reset `req_ready` is 1, `res_valid` and `tbl_rd_valid` are 0, and both configuration registers are 0, so any request then returns a segment trap.
- R2: When the segment number is greater than or equal to the segment count, the result carries trap code 1 and no table read is issued for that request.
- R3: For a legal segment s, the unit reads exactly two words, in this order: first the start at table address + 2*s, then the length at table address + 2*s + 1.
- R4: When the offset is greater than or equal to the segment length, the result carries trap code 2. A segment length of 0 therefore always traps. Every trapped result reports a physical address of 0.
- R5: For a legal access, the result carries trap code 0 and the physical address equals start + offset, modulo 2^AW.
- R6: A table read request stays asserted, with the same address, until `tbl_rd_ready` accepts it. Read data is used only on cycles where `tbl_rsp_valid` is high.
- R7: A result stays valid with the same address and trap code until `res_ready` is high. `req_ready` stays low from the acceptance of a request until its result is taken.
- R8: `cfg_sel` = 0 writes the table address and `cfg_sel` = 1 writes the segment count (its low SEGW+1 bits). A write presented while a translation is in flight is discarded.
- R9: Boundary cases: segment number count-1 is legal, segment number count traps, offset length-1 is legal, and offset length traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: table address, 1: segment count |
| cfg_wdata | input | AW | Configuration write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_seg | input | SEGW | Segment number |
| req_off | input | OFFW | Offset within the segment |
| tbl_rd_valid | output | 1 | Table read request valid |
| tbl_rd_ready | input | 1 | Memory accepts the read |
| tbl_rd_addr | output | AW | Word address of the table read |
| tbl_rsp_valid | input | 1 | Read data valid |
| tbl_rsp_data | input | AW | Read data word |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_paddr | output | AW | Physical address, 0 on a trap |
| res_trap | output | 2 | 0 none, 1 segment number, 2 offset |

## Verification
The bench builds the unit with AW=16, SEGW=4 and OFFW=10. With these values the segment count can reach its full value of 16, every segment number can be tried against it, and limits up to 1023 let random offsets land on both sides of the length. A 16-bit address makes the wrap of start plus offset easy to reach directly. The table sits in a 256-word memory model that stalls its read handshake at random. Reads are logged, so a test can confirm that a segment trap issues no read and that the read address order is correct.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    TRAP_NONE = 2'd0,
    TRAP_SEG  = 2'd1,
    TRAP_OFF  = 2'd2
  } trap_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/seg_cfg_regs.sv
module seg_cfg_regs #(
  parameter int AW = 32,
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          sel,
  input  logic [AW-1:0] wdata,
  input  logic          idle,
  output logic [AW-1:0] tbl_base,
  output logic [LW-1:0] tbl_len
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_base <= '0;
      tbl_len  <= '0;
    end else if (we && idle) begin
      if (sel) tbl_len  <= wdata[LW-1:0];
      else     tbl_base <= wdata;
    end
  end

  // R8: registers frozen while a translation is in flight
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> ($stable(tbl_base) && $stable(tbl_len)));
endmodule

// File: rtl/seg_bound_chk.sv
module seg_bound_chk #(
  parameter int AW   = 32,
  parameter int SEGW = 8,
  parameter int OFFW = 20,
  parameter int LW   = SEGW + 1
) (
  input  logic [SEGW-1:0] seg,
  input  logic [LW-1:0]   len,
  input  logic [OFFW-1:0] off,
  input  logic [AW-1:0]   limit,
  output logic            seg_ok,
  output logic            off_ok
);
  always_comb begin
    seg_ok = LW'(seg) < len;
    off_ok = AW'(off) < limit;
  end
endmodule

// File: rtl/seg_walker.sv
module seg_walker
  import seg_xlate_pkg::*;
#(
  parameter int AW   = 32,
  parameter int SEGW = 8,
  parameter int OFFW = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   tbl_base,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [SEGW-1:0] req_seg,
  input  logic [OFFW-1:0] req_off,
  input  logic            seg_ok,
  input  logic            off_ok,
  output logic [OFFW-1:0] off_held,
  output logic            tbl_rd_valid,
  input  logic            tbl_rd_ready,
  output logic [AW-1:0]   tbl_rd_addr,
  input  logic            tbl_rsp_valid,
  input  logic [AW-1:0]   tbl_rsp_data,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [AW-1:0]   res_paddr,
  output logic [1:0]      res_trap,
  output logic            idle
);
  walk_st_e        st;
  logic [SEGW-1:0] seg_q;
  logic [OFFW-1:0] off_q;
  logic            word_q;
  logic [AW-1:0]   base_q;
  logic [AW-1:0]   paddr_q;
  trap_e           trap_q;

  assign off_held     = off_q;
  assign idle         = (st == ST_IDLE);
  assign req_ready    = (st == ST_IDLE);
  assign tbl_rd_valid = (st == ST_READ);
  assign tbl_rd_addr  = tbl_base + AW'({seg_q, 1'b0}) + AW'(word_q);
  assign res_valid    = (st == ST_DONE);
  assign res_paddr    = paddr_q;
  assign res_trap     = trap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      seg_q   <= '0;
      off_q   <= '0;
      word_q  <= 1'b0;
      base_q  <= '0;
      paddr_q <= '0;
      trap_q  <= TRAP_NONE;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          seg_q  <= req_seg;
          off_q  <= req_off;
          word_q <= 1'b0;
          if (!seg_ok) begin
            trap_q  <= TRAP_SEG;
            paddr_q <= '0;
            st      <= ST_DONE;
          end else begin
            st <= ST_READ;
          end
        end
        ST_READ: if (tbl_rd_ready) st <= ST_WAIT;
        ST_WAIT: if (tbl_rsp_valid) begin
          if (!word_q) begin
            base_q <= tbl_rsp_data;
            word_q <= 1'b1;
            st     <= ST_READ;
          end else begin
            if (off_ok) begin
              paddr_q <= base_q + AW'(off_q);
              trap_q  <= TRAP_NONE;
            end else begin
              paddr_q <= '0;
              trap_q  <= TRAP_OFF;
            end
            st <= ST_DONE;
          end
        end
        ST_DONE: if (res_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6: read request held with a steady address until accepted
  a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd_valid && !tbl_rd_ready) |=> (tbl_rd_valid && $stable(tbl_rd_addr)));
  // R7: result held until taken
  a_r7_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_paddr) && $stable(res_trap)));
  // R7: no new request while a result waits
  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);
  // R2: a segment trap taken straight from acceptance, no read in between
  a_r2_direct_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !seg_ok) |=> (res_valid && res_trap == TRAP_SEG && !tbl_rd_valid));
  // R4: trapped results carry a zero address
  a_r4_trap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_trap != TRAP_NONE) |-> (res_paddr == '0));
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int AW   = 32,
  parameter int SEGW = 8,
  parameter int OFFW = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [SEGW-1:0] req_seg,
  input  logic [OFFW-1:0] req_off,
  output logic            tbl_rd_valid,
  input  logic            tbl_rd_ready,
  output logic [AW-1:0]   tbl_rd_addr,
  input  logic            tbl_rsp_valid,
  input  logic [AW-1:0]   tbl_rsp_data,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [AW-1:0]   res_paddr,
  output logic [1:0]      res_trap
);
  localparam int LW = SEGW + 1;

  logic [AW-1:0]   tbl_base;
  logic [LW-1:0]   tbl_len;
  logic            idle;
  logic            seg_ok;
  logic            off_ok;
  logic [OFFW-1:0] off_held;

  seg_cfg_regs #(.AW(AW), .LW(LW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .idle(idle), .tbl_base(tbl_base), .tbl_len(tbl_len)
  );

  seg_bound_chk #(.AW(AW), .SEGW(SEGW), .OFFW(OFFW), .LW(LW)) u_chk (
    .seg(req_seg), .len(tbl_len), .off(off_held), .limit(tbl_rsp_data),
    .seg_ok(seg_ok), .off_ok(off_ok)
  );

  seg_walker #(.AW(AW), .SEGW(SEGW), .OFFW(OFFW)) u_walk (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg), .req_off(req_off),
    .seg_ok(seg_ok), .off_ok(off_ok), .off_held(off_held),
    .tbl_rd_valid(tbl_rd_valid), .tbl_rd_ready(tbl_rd_ready), .tbl_rd_addr(tbl_rd_addr),
    .tbl_rsp_valid(tbl_rsp_valid), .tbl_rsp_data(tbl_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_paddr(res_paddr), .res_trap(res_trap),
    .idle(idle)
  );
endmodule

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
  localparam int AW = 16, SEGW = 4, OFFW = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [AW-1:0] cfg_wdata = '0;
  logic req_valid = 0, req_ready;
  logic [SEGW-1:0] req_seg = '0;
  logic [OFFW-1:0] req_off = '0;
  logic tbl_rd_valid, tbl_rd_ready = 0;
  logic [AW-1:0] tbl_rd_addr;
  logic tbl_rsp_valid = 0;
  logic [AW-1:0] tbl_rsp_data = '0;
  logic res_valid, res_ready = 0;
  logic [AW-1:0] res_paddr;
  logic [1:0] res_trap;

  always #5 clk = ~clk;

  seg_xlate #(.AW(AW), .SEGW(SEGW), .OFFW(OFFW)) u0 (.*);

  logic [AW-1:0] mem [0:255];
  logic [AW-1:0] rlog [0:15];
  int unsigned rd_cnt = 0;
  int nchk = 0, nerr = 0;
  int cyc = 0;
  logic [AW-1:0] m_tb = '0;
  int m_len = 0;

  // table memory: random accept stalls, data one cycle after accept
  always @(posedge clk) begin
    tbl_rsp_valid <= 1'b0;
    if (tbl_rd_valid && tbl_rd_ready) begin
      tbl_rsp_valid <= 1'b1;
      tbl_rsp_data  <= mem[tbl_rd_addr[7:0]];
      rlog[rd_cnt[3:0]] <= tbl_rd_addr;
      rd_cnt <= rd_cnt + 1;
    end
    tbl_rd_ready <= ($urandom % 3) != 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_trap(input int s, input int o);
    if (s >= m_len) return 2'd1;
    if (o >= int'(mem[8'(m_tb + 16'(2*s) + 16'd1)])) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [AW-1:0] exp_paddr(input int s, input int o);
    if (exp_trap(s, o) != 0) return '0;
    return mem[8'(m_tb + 16'(2*s))] + AW'(o);
  endfunction

  task automatic cfg_write(input logic sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
    if (sel) m_len = int'(d[SEGW:0]); else m_tb = d;
  endtask

  task automatic translate(input int s, input int o, input bit busy_wr, input string req);
    int unsigned rc0;
    logic [1:0] t;
    logic [AW-1:0] p;
    int hold;
    @(negedge clk);
    rc0 = rd_cnt;
    req_valid = 1; req_seg = SEGW'(s); req_off = OFFW'(o);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
    if (busy_wr) begin
      cfg_we = 1; cfg_sel = 1; cfg_wdata = '0;
      @(posedge clk); #1;
      cfg_we = 0;
      cfg_sel = 0; cfg_wdata = 16'h00F0;
      cfg_we = 1;
      @(posedge clk); #1;
      cfg_we = 0;
    end
    @(negedge clk);
    while (!res_valid) @(negedge clk);
    t = res_trap; p = res_paddr;
    chk({req, " R2/R4/R5 trap"}, 32'(t), 32'(exp_trap(s, o)));
    chk({req, " R5 paddr"}, 32'(p), 32'(exp_paddr(s, o)));
    if (exp_trap(s, o) == 2'd1)
      chk({req, " R2 no table read"}, rd_cnt - rc0, 0);
    else begin
      chk({req, " R3 read count"}, rd_cnt - rc0, 2);
      chk({req, " R3 start addr"}, 32'(rlog[rc0[3:0]]), 32'(16'(m_tb + 16'(2*s))));
      chk({req, " R3 length addr"}, 32'(rlog[4'(rc0 + 1)]), 32'(16'(m_tb + 16'(2*s) + 16'd1)));
    end
    hold = int'($urandom % 3);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk({req, " R7 held"}, {29'd0, res_valid, res_trap}, {29'd1, t});
      chk({req, " R7 req_ready low"}, 32'(req_ready), 0);
    end
    @(negedge clk);
    res_ready = 1;
    @(posedge clk); #1;
    res_ready = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
    void'($urandom(32'h5E6A11));
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nerr++; nchk++;
        $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
      end
    end
  end

  initial begin : main
    int s, o;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 req_ready", 32'(req_ready), 1);
    chk("R1 res_valid", 32'(res_valid), 0);
    chk("R1 tbl_rd_valid", 32'(tbl_rd_valid), 0);
    translate(0, 0, 0, "R1 zero count");

    // directed cases
    cfg_write(0, 16'd40);
    cfg_write(1, 16'd5);
    mem[40 + 8] = 16'h1000; mem[40 + 9] = 16'd100;
    translate(4, 99, 0, "R9 last seg, last off");
    translate(4, 100, 0, "R9 off == limit");
    translate(5, 0, 0, "R9 seg == count");
    mem[40] = 16'hFFF0; mem[41] = 16'd500;
    translate(0, 32, 0, "R5 wrap");
    mem[42] = 16'h0200; mem[43] = 16'd0;
    translate(1, 0, 0, "R4 zero limit");

    // R8: writes during a translation are discarded
    mem[46] = 16'h0300; mem[47] = 16'd20;
    translate(3, 5, 1, "R8 busy write");
    translate(3, 7, 0, "R8 config kept");
    cfg_write(1, 16'd16);
    translate(15, 1, 0, "R8 idle write");

    // random sweep
    for (int r = 0; r < 400; r++) begin
      if (r % 50 == 0) begin
        cfg_write(0, 16'($urandom % 200));
        cfg_write(1, 16'($urandom % 17));
        for (int i = 0; i < 16; i++)
          mem[8'(m_tb + 16'(2*i) + 16'd1)] = 16'($urandom % 1100);
      end
      s = int'($urandom % 16);
      o = int'($urandom % 1024);
      translate(s, o, 0, "R5 random");
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule